// File: doc/BRIEF.md
# Transceiver Rate-Reconfiguration Sequencer

This block steps one serial transceiver channel from its present line-rate profile to another. A one-cycle start pulse begins a fixed run. The block pulses a global reconfiguration reset and writes a mode-select value. It then places the transmit path and after it the receive path in reset, and waits until each direction reports both acknowledge bits.

Once the reconfiguration engine signals ready, the block writes a profile index taken from an ordered, parameterised transition list. It raises a request and holds it until the engine acknowledges. It waits for that acknowledge to drop, and then for a done flag. Next it writes the mode value a second time and releases transmit reset, then receive reset. Last, it samples a link-status word to decide between pass and fail.

Each wait has a programmable cycle limit. When a limit runs out, the run ends with a fail code that names the stalled step. One run moves the list pointer by at most one entry, and only a passing run moves it. The engine and the PHY sit outside the block.

Top module: `xcvr_rate_seq`

## Requirements
- R1: After synchronous reset every output is low and the list index is 0.
- R2: An accepted start gives exactly one cycle of `cfg_rst_o`. A `mode_wr_o` pulse carrying `MODE_VAL` follows it, before any reset bit is set. A passing run issues a second mode write after the done flag and before the resets are released.
- R3: `rst_ctrl_o` drives transmit reset on bit 2 and receive reset on bit 1, and keeps bit 0 at zero. Starting from 0, a passing run shows the values 4, 6, 2, 0 in that order.
- R4: The block moves past the reset stage only when `tx_ack_i` equals 2'b11 and then `rx_ack_i` equals 2'b11. A partial value such as 2'b01 does not count.
- R5: After the resets are acknowledged, the block waits for `eng_ready_i`. It then pulses `prof_wr_o` with `prof_o` set to the current list entry, and only after that raises `req_o`.
- R6: `req_o` stays high until `ack_i` is seen and is then dropped. `done_i` is accepted only after `ack_i` has returned low.
- R7: Entry k of the list is bits [k*PROF_W +: PROF_W] of `PROF_LIST`. Each passing run advances the index by one and wraps from the last entry to 0. A failing run leaves the index unchanged.
- R8: The run passes only if `(stat_i & STAT_MASK) == STAT_GOOD`. Bits outside the mask are ignored. Any other value ends the run with fail code 7.
- R9: A wait state that lasts `tmo_cycles_i` cycles without its condition ends the run in fail. The codes are 1 for transmit ack, 2 for receive ack, 3 for ready, 4 for acknowledge, 5 for acknowledge low and 6 for done. The reset word is left as it was. A limit of 0 disables the timeout.
- R10: `busy_o` is high from the accepted start until `pass_o` or `fail_o` rises. A start while busy has no effect. `pass_o`, `fail_o` and `fail_code_o` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| tmo_cycles_i | input | TMO_W | Wait-state cycle limit, 0 disables |
| cfg_rst_o | output | 1 | Global reconfiguration reset pulse |
| mode_wr_o | output | 1 | Mode-select write strobe |
| mode_o | output | MODE_W | Mode-select value |
| rst_ctrl_o | output | 3 | Channel reset word (bit 2 TX, bit 1 RX) |
| tx_ack_i | input | 2 | Transmit reset acknowledge status |
| rx_ack_i | input | 2 | Receive reset acknowledge status |
| eng_ready_i | input | 1 | Reconfiguration engine ready |
| prof_wr_o | output | 1 | Profile write strobe |
| prof_o | output | PROF_W | Target profile index |
| req_o | output | 1 | Reconfiguration request |
| ack_i | input | 1 | Request acknowledge |
| done_i | input | 1 | Reconfiguration done |
| stat_i | input | STAT_W | Link status word |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run passed |
| fail_o | output | 1 | Last run failed |
| fail_code_o | output | 3 | Step that failed |
| list_idx_o | output | IDX_W | Current transition-list index |

## Verification
The assertions assume that `tmo_cycles_i` stays constant while a run is in progress. The counter bound depends on that limit not shrinking under a running count. The bench changes the limit only while the block is idle.

The request-hold and reset-order properties assume that the engine acknowledges only a raised request. The bench models the PHY and the engine as registered responders to the block's own outputs. Its stall modes only hold back or freeze a response, and never produce one without a cause.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  localparam int WORD_W = 3;
  localparam int TX_BIT = 2;
  localparam int RX_BIT = 1;
  localparam int FC_W   = 3;

  typedef enum logic [4:0] {
    S_IDLE, S_CFG_ON, S_CFG_OFF, S_MODE_PRE, S_TX_ON, S_RX_ON,
    S_W_TXACK, S_W_RXACK, S_W_READY, S_LOAD, S_REQ, S_W_ACKLOW,
    S_W_DONE, S_MODE_POST, S_TX_OFF, S_RX_OFF, S_CHECK
  } seq_st_e;

  localparam logic [FC_W-1:0] FC_NONE   = 3'd0;
  localparam logic [FC_W-1:0] FC_TXACK  = 3'd1;
  localparam logic [FC_W-1:0] FC_RXACK  = 3'd2;
  localparam logic [FC_W-1:0] FC_READY  = 3'd3;
  localparam logic [FC_W-1:0] FC_ACK    = 3'd4;
  localparam logic [FC_W-1:0] FC_ACKLOW = 3'd5;
  localparam logic [FC_W-1:0] FC_DONE   = 3'd6;
  localparam logic [FC_W-1:0] FC_LOCK   = 3'd7;

  function automatic logic is_wait(seq_st_e s);
    return (s == S_W_TXACK) || (s == S_W_RXACK) || (s == S_W_READY) ||
           (s == S_REQ) || (s == S_W_ACKLOW) || (s == S_W_DONE);
  endfunction

endpackage

// File: rtl/xrs_wait_timer.sv
module xrs_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             expire_o
);

  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_q <= '0;
    else if (en_i && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && (lim_i != '0) && (cnt_q >= lim_i - 1'b1);

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
    (en_i && lim_i != '0) |-> (cnt_q < lim_i)); // R9

endmodule

// File: rtl/xrs_profile_list.sv
module xrs_profile_list #(
  parameter int N_PROF = 4,
  parameter int PROF_W = 4,
  parameter logic [N_PROF*PROF_W-1:0] PROF_LIST = '0,
  localparam int IDX_W = (N_PROF > 1) ? $clog2(N_PROF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PROF_W-1:0] prof_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PROF - 1);

  logic [PROF_W-1:0] tbl [N_PROF];
  logic [IDX_W-1:0]  idx_q;

  for (genvar g = 0; g < N_PROF; g++) begin : g_ent
    assign tbl[g] = PROF_LIST[g*PROF_W +: PROF_W];
  end

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= '0;
    else if (adv_i)
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign prof_o = tbl[idx_q];

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST); // R7

endmodule

// File: rtl/xrs_ctrl.sv
module xrs_ctrl
  import xrs_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] MODE_VAL = '0,
  parameter int PROF_W = 4,
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] STAT_MASK = 8'h0F,
  parameter logic [STAT_W-1:0] STAT_GOOD = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tmo_exp_i,
  input  logic [1:0]        tx_ack_i,
  input  logic [1:0]        rx_ack_i,
  input  logic              eng_ready_i,
  input  logic              ack_i,
  input  logic              done_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [PROF_W-1:0] prof_i,
  output logic              tmr_clr_o,
  output logic              tmr_en_o,
  output logic              adv_o,
  output logic              cfg_rst_o,
  output logic              mode_wr_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [WORD_W-1:0] rst_ctrl_o,
  output logic              prof_wr_o,
  output logic [PROF_W-1:0] prof_o,
  output logic              req_o,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [FC_W-1:0]   fail_code_o
);

  seq_st_e st_q, st_d;
  logic    fin_pass, fin_fail;
  logic [FC_W-1:0] code_d;

  always_comb begin
    st_d     = st_q;
    fin_pass = 1'b0;
    fin_fail = 1'b0;
    code_d   = FC_NONE;
    unique case (st_q)
      S_IDLE:      if (start_i) st_d = S_CFG_ON;
      S_CFG_ON:    st_d = S_CFG_OFF;
      S_CFG_OFF:   st_d = S_MODE_PRE;
      S_MODE_PRE:  st_d = S_TX_ON;
      S_TX_ON:     st_d = S_RX_ON;
      S_RX_ON:     st_d = S_W_TXACK;
      S_W_TXACK:
        if (tx_ack_i == 2'b11) st_d = S_W_RXACK;
        else if (tmo_exp_i) begin st_d = S_IDLE; fin_fail = 1'b1; code_d = FC_TXACK; end
      S_W_RXACK:
        if (rx_ack_i == 2'b11) st_d = S_W_READY;
        else if (tmo_exp_i) begin st_d = S_IDLE; fin_fail = 1'b1; code_d = FC_RXACK; end
      S_W_READY:
        if (eng_ready_i) st_d = S_LOAD;
        else if (tmo_exp_i) begin st_d = S_IDLE; fin_fail = 1'b1; code_d = FC_READY; end
      S_LOAD:      st_d = S_REQ;
      S_REQ:
        if (ack_i) st_d = S_W_ACKLOW;
        else if (tmo_exp_i) begin st_d = S_IDLE; fin_fail = 1'b1; code_d = FC_ACK; end
      S_W_ACKLOW:
        if (!ack_i) st_d = S_W_DONE;
        else if (tmo_exp_i) begin st_d = S_IDLE; fin_fail = 1'b1; code_d = FC_ACKLOW; end
      S_W_DONE:
        if (done_i) st_d = S_MODE_POST;
        else if (tmo_exp_i) begin st_d = S_IDLE; fin_fail = 1'b1; code_d = FC_DONE; end
      S_MODE_POST: st_d = S_TX_OFF;
      S_TX_OFF:    st_d = S_RX_OFF;
      S_RX_OFF:    st_d = S_CHECK;
      S_CHECK: begin
        st_d = S_IDLE;
        if ((stat_i & STAT_MASK) == STAT_GOOD) fin_pass = 1'b1;
        else begin fin_fail = 1'b1; code_d = FC_LOCK; end
      end
      default:     st_d = S_IDLE;
    endcase
  end

  assign tmr_clr_o = (st_d != st_q);
  assign tmr_en_o  = is_wait(st_q);
  assign adv_o     = fin_pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      cfg_rst_o   <= 1'b0;
      mode_wr_o   <= 1'b0;
      mode_o      <= '0;
      rst_ctrl_o  <= '0;
      prof_wr_o   <= 1'b0;
      prof_o      <= '0;
      req_o       <= 1'b0;
      busy_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_code_o <= FC_NONE;
    end else begin
      st_q      <= st_d;
      cfg_rst_o <= (st_d == S_CFG_ON);
      mode_wr_o <= (st_d == S_MODE_PRE) || (st_d == S_MODE_POST);
      if ((st_d == S_MODE_PRE) || (st_d == S_MODE_POST)) mode_o <= MODE_VAL;
      if (st_d == S_TX_ON)  rst_ctrl_o[TX_BIT] <= 1'b1;
      if (st_d == S_RX_ON)  rst_ctrl_o[RX_BIT] <= 1'b1;
      if (st_d == S_TX_OFF) rst_ctrl_o[TX_BIT] <= 1'b0;
      if (st_d == S_RX_OFF) rst_ctrl_o[RX_BIT] <= 1'b0;
      prof_wr_o <= (st_d == S_LOAD);
      if (st_d == S_LOAD) prof_o <= prof_i;
      req_o     <= (st_d == S_REQ);
      busy_o    <= (st_d != S_IDLE);
      if (st_q == S_IDLE && start_i) begin
        pass_o      <= 1'b0;
        fail_o      <= 1'b0;
        fail_code_o <= FC_NONE;
      end
      if (fin_pass) pass_o <= 1'b1;
      if (fin_fail) begin
        fail_o      <= 1'b1;
        fail_code_o <= code_d;
      end
    end
  end

  AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_ctrl_o[RX_BIT]) |-> rst_ctrl_o[TX_BIT]); // R3
  AST_TX_REL_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_ctrl_o[RX_BIT]) |-> !rst_ctrl_o[TX_BIT]); // R3
  AST_BIT0_LOW: assert property (@(posedge clk) disable iff (rst)
    !rst_ctrl_o[0]); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o || fail_o)); // R6
  AST_PROF_STABLE: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $stable(prof_o)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, pass_o, fail_o})); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !cfg_rst_o); // R10
  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_rst_o |=> !cfg_rst_o); // R2

endmodule

// File: rtl/xcvr_rate_seq.sv
module xcvr_rate_seq
  import xrs_pkg::*;
#(
  parameter int N_PROF = 4,
  parameter int PROF_W = 4,
  parameter logic [N_PROF*PROF_W-1:0] PROF_LIST = {4'd3, 4'd2, 4'd5, 4'd1},
  parameter int TMO_W  = 16,
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] MODE_VAL = '0,
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] STAT_MASK = 8'h0F,
  parameter logic [STAT_W-1:0] STAT_GOOD = 8'h01,
  localparam int IDX_W = (N_PROF > 1) ? $clog2(N_PROF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TMO_W-1:0]  tmo_cycles_i,
  output logic              cfg_rst_o,
  output logic              mode_wr_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [2:0]        rst_ctrl_o,
  input  logic [1:0]        tx_ack_i,
  input  logic [1:0]        rx_ack_i,
  input  logic              eng_ready_i,
  output logic              prof_wr_o,
  output logic [PROF_W-1:0] prof_o,
  output logic              req_o,
  input  logic              ack_i,
  input  logic              done_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [2:0]        fail_code_o,
  output logic [IDX_W-1:0]  list_idx_o
);

  logic              tmr_clr, tmr_en, tmr_exp, adv;
  logic [PROF_W-1:0] cur_prof;

  xrs_wait_timer #(.TMO_W(TMO_W)) timer_i (
    .clk(clk), .rst(rst), .clr_i(tmr_clr), .en_i(tmr_en),
    .lim_i(tmo_cycles_i), .expire_o(tmr_exp)
  );

  xrs_profile_list #(.N_PROF(N_PROF), .PROF_W(PROF_W), .PROF_LIST(PROF_LIST)) list_i (
    .clk(clk), .rst(rst), .adv_i(adv), .idx_o(list_idx_o), .prof_o(cur_prof)
  );

  xrs_ctrl #(
    .MODE_W(MODE_W), .MODE_VAL(MODE_VAL), .PROF_W(PROF_W), .STAT_W(STAT_W),
    .STAT_MASK(STAT_MASK), .STAT_GOOD(STAT_GOOD)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .tmo_exp_i(tmr_exp),
    .tx_ack_i(tx_ack_i), .rx_ack_i(rx_ack_i), .eng_ready_i(eng_ready_i),
    .ack_i(ack_i), .done_i(done_i), .stat_i(stat_i), .prof_i(cur_prof),
    .tmr_clr_o(tmr_clr), .tmr_en_o(tmr_en), .adv_o(adv),
    .cfg_rst_o(cfg_rst_o), .mode_wr_o(mode_wr_o), .mode_o(mode_o),
    .rst_ctrl_o(rst_ctrl_o), .prof_wr_o(prof_wr_o), .prof_o(prof_o),
    .req_o(req_o), .busy_o(busy_o), .pass_o(pass_o), .fail_o(fail_o),
    .fail_code_o(fail_code_o)
  );

endmodule

// File: tb/xcvr_rate_seq_tb.sv
module xcvr_rate_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_PROF = 4;
  localparam int PROF_W = 4;
  localparam logic [N_PROF*PROF_W-1:0] LIST = {4'd3, 4'd2, 4'd5, 4'd1};
  localparam logic [1:0] MODE_V = 2'd1;
  localparam int N_ROWS = 12;
  // row = {stall[2:0], stat[7:0], expected code[2:0]}; stall: 0 none, 1 tx partial,
  // 2 rx, 3 ready, 4 ack never, 5 ack stuck (done early), 6 done never
  localparam logic [13:0] ROWS [N_ROWS] = '{
    {3'd0, 8'h01, 3'd0}, {3'd0, 8'hF1, 3'd0}, {3'd1, 8'h01, 3'd1},
    {3'd2, 8'h01, 3'd2}, {3'd3, 8'h01, 3'd3}, {3'd4, 8'h01, 3'd4},
    {3'd5, 8'h01, 3'd5}, {3'd6, 8'h01, 3'd6}, {3'd0, 8'h05, 3'd7},
    {3'd0, 8'h01, 3'd0}, {3'd0, 8'h01, 3'd0}, {3'd0, 8'h01, 3'd0}
  };

  logic clk = 0, rst = 1, start = 0;
  logic [15:0] tmo = 16'd40;
  logic cfg_rst, mode_wr, prof_wr, req, busy, pass_f, fail_f;
  logic [1:0] mode, tx_ack = 0, rx_ack = 0, idx;
  logic [2:0] word, code;
  logic [3:0] prof;
  logic ack = 0, done = 0, armed = 0;
  logic [7:0] stat = 8'h01;
  logic [2:0] stall = 0;
  logic eng_ready;

  int n_checks = 0, n_fail = 0;
  int cfg_cnt, mode_cnt, pwr_cnt, wn;
  logic order_bad, mode_bad, req_early;
  logic [3:0] prof_seen;
  logic [2:0] wprev;
  logic [2:0] wlog [4];
  logic mon_clr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_rate_seq #(.N_PROF(N_PROF), .PROF_W(PROF_W), .PROF_LIST(LIST), .MODE_VAL(MODE_V)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .tmo_cycles_i(tmo),
    .cfg_rst_o(cfg_rst), .mode_wr_o(mode_wr), .mode_o(mode), .rst_ctrl_o(word),
    .tx_ack_i(tx_ack), .rx_ack_i(rx_ack), .eng_ready_i(eng_ready),
    .prof_wr_o(prof_wr), .prof_o(prof), .req_o(req), .ack_i(ack), .done_i(done),
    .stat_i(stat), .busy_o(busy), .pass_o(pass_f), .fail_o(fail_f),
    .fail_code_o(code), .list_idx_o(idx)
  );

  // PHY and engine models
  assign eng_ready = (stall != 3'd3);
  always @(posedge clk) begin
    tx_ack <= (stall == 3'd1) ? {1'b0, word[2]} : {2{word[2]}};
    rx_ack <= (stall == 3'd2) ? 2'b00 : {2{word[1]}};
    if (stall == 3'd5) ack <= ack | req;
    else ack <= req && (stall != 3'd4);
    if (cfg_rst) armed <= 1'b0;
    else if (ack) armed <= 1'b1;
    done <= (stall == 3'd5) ? armed : (armed && !ack && stall != 3'd6);
  end

  // Output monitor
  always @(negedge clk) begin
    if (mon_clr) begin
      cfg_cnt = 0; mode_cnt = 0; pwr_cnt = 0; wn = 0;
      order_bad = 0; mode_bad = 0; req_early = 0; prof_seen = 0; wprev = word;
    end else begin
      if (cfg_rst) cfg_cnt++;
      if (mode_wr) begin mode_cnt++; if (mode != MODE_V) mode_bad = 1; end
      if (prof_wr) begin pwr_cnt++; prof_seen = prof; end
      if (req && pwr_cnt == 0) req_early = 1;
      if (word != wprev) begin
        if (cfg_cnt == 0 || mode_cnt == 0) order_bad = 1;
        if (wn < 4) wlog[wn] = word;
        wn++;
        wprev = word;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] entry(input int k);
    return LIST[k*PROF_W +: PROF_W];
  endfunction

  task automatic run(input logic [2:0] st, input logic [7:0] sv, input int extra_start);
    @(negedge clk);
    stall = st; stat = sv; mon_clr = 1;
    @(negedge clk);
    mon_clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 4000 && busy; i++) begin
      @(negedge clk);
      if (i == extra_start) start = 1;
      else start = 0;
    end
    start = 0;
  endtask

  int exp_idx = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!busy && !pass_f && !fail_f && !cfg_rst && !req && !prof_wr && !mode_wr,
        "R1 flags low", {busy, pass_f, fail_f}, 0);
    chk(word == 0 && idx == 0 && code == 0, "R1 word/index/code", {word, idx, code}, 0);
    rst = 0;
    @(negedge clk);

    for (int r = 0; r < N_ROWS; r++) begin
      logic [2:0] st, ec;
      logic [7:0] sv;
      logic [2:0] w0;
      {st, sv, ec} = ROWS[r];
      w0 = word;
      run(st, sv, -1);
      chk(!busy, "R10 busy low at end", busy, 0);
      chk(cfg_cnt == 1, "R2 single cfg pulse", cfg_cnt, 1);
      chk(!order_bad && !mode_bad, "R2 cfg/mode before resets", {order_bad, mode_bad}, 0);
      chk(!req_early, "R5 profile written before request", req_early, 0);
      chk(!req, "R6 request low at end", req, 0);
      if (ec == 0) begin
        chk(pass_f && !fail_f, "R8 pass", {pass_f, fail_f}, 2);
        chk(prof_seen == entry(exp_idx), "R7 profile from list", prof_seen, entry(exp_idx));
        chk(mode_cnt == 2, "R2 two mode writes", mode_cnt, 2);
        chk(word == 0, "R3 resets released", word, 0);
        if (w0 == 0)
          chk(wn == 4 && {wlog[0], wlog[1], wlog[2], wlog[3]} == 12'b100_110_010_000,
              "R3 word order 4,6,2,0", {wlog[0], wlog[1], wlog[2], wlog[3]}, 12'b100_110_010_000);
        exp_idx = (exp_idx + 1) % N_PROF;
      end else begin
        chk(fail_f && !pass_f && code == ec, "R9 fail code", code, ec);
        if (ec == 3'd7) chk(word == 0, "R8 resets released on lock fail", word, 0);
        else chk(word == 3'b110, "R9 resets held on timeout", word, 6);
        if (ec == 3'd1) chk(pwr_cnt == 0, "R4 partial ack blocks", pwr_cnt, 0);
        if (ec == 3'd5) chk(mode_cnt == 1, "R6 early done ignored", mode_cnt, 1);
      end
      chk(idx == exp_idx, "R7 list index", idx, exp_idx);
      repeat (3) @(negedge clk);
      chk(pass_f == (ec == 0) && fail_f == (ec != 0), "R10 result held", {pass_f, fail_f}, (ec == 0) ? 2 : 1);
    end

    // R10: start while busy is ignored
    run(3'd0, 8'h01, 10);
    chk(cfg_cnt == 1, "R10 second start ignored", cfg_cnt, 1);
    exp_idx = (exp_idx + 1) % N_PROF;
    chk(idx == exp_idx, "R10 index moved once", idx, exp_idx);
    repeat (30) @(negedge clk);
    chk(!busy && cfg_cnt == 1, "R10 no late run", {busy, 1'b0}, 0);

    // R9: limit 0 disables timeout
    @(negedge clk);
    tmo = 16'd0; stall = 3'd3; mon_clr = 1;
    @(negedge clk);
    mon_clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (300) @(negedge clk);
    chk(busy && !fail_f, "R9 zero limit waits", {busy, fail_f}, 2);
    stall = 3'd0;
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    chk(pass_f && prof_seen == entry(exp_idx), "R9 zero limit completes", prof_seen, entry(exp_idx));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule